// File: doc/BRIEF.md
# Programmable Clock Generator with Glitch-Free Divider

This block turns a source clock into a divided clock whose division ratio, mode and idle level are set through a control word written from a separate bus clock domain. Two division modes are offered: a power-of-two mode whose ratio grows as a power of two with the divide field, and an integer mode whose ratio equals the divide field. In integer mode, odd ratios can optionally get a half-cycle stretch of their high phase, which brings the duty cycle close to fifty percent. When the generator is stopped, its output rests at a programmable idle level. Starting and stopping happen only on a divided-period boundary, so no short pulse leaks out.

Every write travels into the generator's domain through a toggle handshake. A busy flag stays high until the generator has acted on the write, and a write that arrives while busy is dropped. Each write carries an operation code. One code loads the whole configuration and leaves the run bit alone, another changes only the run bit, and a third returns the generator to its defaults. The block also chooses which source oscillator to request. On a source change it keeps requesting the old oscillator until the new one reports ready, and the index on `src_sel` steers an external clock multiplexer.

Top module: `clkgen_div`

## Requirements
- R1: With the power-of-two bit set, the output period is 2^(D+1) source cycles, where D is the divide field, and the high time is half the period. The exponent is capped at 15.
- R2: With the power-of-two bit clear and D of 2 or more, the period is D source cycles. Without the stretch bit, the output is high for floor(D/2) source cycles.
- R3: In integer mode with D equal to 0 or 1, the source clock passes through undivided.
- R4: With the stretch bit set, integer mode and an odd D of 3 or more, the high time is floor(D/2) source cycles plus one half-cycle. For an even D the stretch bit has no effect.
- R5: While the generator is stopped, the output holds the idle-level bit of the active configuration. After a reset that level is low.
- R6: A write accepted while `busy` is low drives `busy` high on the next bus clock. `busy` falls again once the generator domain has applied the write.
- R7: A write presented while `busy` is high is ignored and leaves the active configuration unchanged.
- R8: Operation code 0 (configure) loads every field except the run bit, which keeps its value. Operation code 1 (run) changes only the run bit. Operation code 3 is accepted but changes nothing.
- R9: After a write that clears the run bit, `busy` stays high until the output has stopped. At the first bus cycle where `busy` is low again, `gen_on` is low and the output sits at the idle level.
- R10: The generator starts and stops only on a divided-period boundary, so no output pulse is shorter than the shorter of the configured high and low phases.
- R11: When the source field changes, `src_req` keeps the old source's bit and adds the new one. Once the new source's `src_rdy` bit is seen, the old bit drops and `src_sel` takes the new index.
- R12: Operation code 2 (reset) stops the output immediately and restores the defaults: all fields zero, source 0 and idle level low.
- R13: `clk_pin` copies `clk_out` while the pin-enable field is set and is low otherwise. `stby_keep` shows the run-in-standby field of the active configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Bus-side clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| gen_clk | input | 1 | Selected source clock driving the divider |
| gen_rst | input | 1 | Synchronous active-high reset, generator domain |
| wr_en | input | 1 | Write strobe |
| wr_op | input | 2 | Operation: 0 configure, 1 run, 2 reset, 3 none |
| wr_src | input | 2 | Source select field |
| wr_div | input | 8 | Divide field D |
| wr_pow2 | input | 1 | Power-of-two mode bit |
| wr_oov | input | 1 | Idle output level |
| wr_dcc | input | 1 | Odd-ratio duty stretch bit |
| wr_pin_oe | input | 1 | Pin output enable |
| wr_stby | input | 1 | Run-in-standby field |
| wr_run | input | 1 | Run bit |
| busy | output | 1 | Write in flight to the generator domain |
| gen_on | output | 1 | Generator running, synchronized to bus domain |
| src_rdy | input | 4 | Per-source ready flags |
| src_req | output | 4 | Per-source request flags |
| src_sel | output | 2 | Source index in use |
| clk_out | output | 1 | Divided clock |
| clk_pin | output | 1 | Clock for the I/O pin |
| stby_keep | output | 1 | Run-in-standby field in effect |

## Verification
The hardest state to reach from the ports is a stop request that is pending while a long divided period runs out, because that is the only time a correct design keeps `busy` high well beyond the handshake delay. The bench selects power-of-two mode with D equal to 8, which gives a 512-cycle period. It clears the run bit and checks that `busy` and `gen_on` are still high tens of bus cycles later. A write is also placed on the bus cycle right after an accepted one, so that it lands in the busy window, and the bench then confirms that the period follows the first write only.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    localparam int SRC_W  = 2;
    localparam int NSRC   = 1 << SRC_W;
    localparam int DIV_W  = 8;
    localparam int CNT_W  = 16;
    localparam int EXP_MAX = CNT_W - 1;

    typedef enum logic [1:0] {
        OP_CFG   = 2'd0,
        OP_RUN   = 2'd1,
        OP_RESET = 2'd2,
        OP_NONE  = 2'd3
    } gen_op_e;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic [DIV_W-1:0] div;
        logic             pow2;
        logic             oov;
        logic             dcc;
        logic             pin_oe;
        logic             stby;
        logic             run;
    } gen_cfg_t;

    localparam gen_cfg_t CFG_DEFAULT = '0;

    // Divided period in source cycles for a configuration.
    function automatic logic [CNT_W-1:0] period_of(input gen_cfg_t c);
        int e;
        if (c.pow2) begin
            e = int'(c.div) + 1;
            if (e > EXP_MAX) e = EXP_MAX;
            return CNT_W'(1) << e;
        end
        if (c.div <= DIV_W'(1)) return CNT_W'(1);
        return CNT_W'(c.div);
    endfunction

    // Half-cycle stretch applies to odd integer ratios of 3 or more.
    function automatic logic stretch_of(input gen_cfg_t c);
        return c.dcc && !c.pow2 && c.div[0] && (c.div > DIV_W'(2));
    endfunction

    function automatic logic [NSRC-1:0] onehot_src(input logic [SRC_W-1:0] s);
        logic [NSRC-1:0] r;
        r = '0;
        r[s] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/clkgen_sync.sv
module clkgen_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/clkgen_bus_port.sv
module clkgen_bus_port
    import clkgen_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  gen_op_e  wr_op,
    input  gen_cfg_t wr_cfg,
    input  logic     ack_s,
    output logic     req_tgl,
    output gen_cfg_t sh_cfg,
    output gen_op_e  sh_op,
    output logic     busy
);
    // The shadow stays frozen while busy, so the generator side may
    // sample it without its own synchronizer once the toggle arrives.
    always_ff @(posedge clk) begin
        if (rst) begin
            req_tgl <= 1'b0;
            busy    <= 1'b0;
            sh_cfg  <= CFG_DEFAULT;
            sh_op   <= OP_NONE;
        end else if (wr_en && !busy) begin
            sh_cfg  <= wr_cfg;
            sh_op   <= wr_op;
            req_tgl <= ~req_tgl;
            busy    <= 1'b1;
        end else if (busy && (ack_s == req_tgl)) begin
            busy    <= 1'b0;
        end
    end
endmodule

// File: rtl/clkgen_gen_ctrl.sv
module clkgen_gen_ctrl
    import clkgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_s,
    input  gen_cfg_t         sh_cfg,
    input  gen_op_e          sh_op,
    input  logic             running,
    input  logic [NSRC-1:0]  rdy_s,
    output gen_cfg_t         cfg_act,
    output logic             swr,
    output logic             ack_tgl,
    output logic [NSRC-1:0]  src_req,
    output logic [SRC_W-1:0] src_sel
);
    logic     req_d;
    logic     pend;
    logic     new_req;
    gen_cfg_t cfg_new;

    assign new_req = req_s ^ req_d;

    always_comb begin
        cfg_new = cfg_act;
        case (sh_op)
            OP_CFG: begin
                cfg_new     = sh_cfg;
                cfg_new.run = cfg_act.run;
            end
            OP_RUN:   cfg_new.run = sh_cfg.run;
            OP_RESET: cfg_new = CFG_DEFAULT;
            default:  cfg_new = cfg_act;
        endcase
    end

    // Apply the request, then acknowledge once the run state has settled.
    always_ff @(posedge clk) begin
        if (rst) begin
            req_d   <= 1'b0;
            pend    <= 1'b0;
            ack_tgl <= 1'b0;
            cfg_act <= CFG_DEFAULT;
            swr     <= 1'b0;
        end else begin
            swr <= 1'b0;
            if (new_req) begin
                req_d   <= req_s;
                pend    <= 1'b1;
                cfg_act <= cfg_new;
                swr     <= (sh_op == OP_RESET);
            end else if (pend && (cfg_act.run == running)) begin
                ack_tgl <= req_d;
                pend    <= 1'b0;
            end
        end
    end

    // Keep the current source requested until the target reports ready.
    always_ff @(posedge clk) begin
        if (rst || swr) begin
            src_sel <= '0;
        end else if ((cfg_act.src != src_sel) && rdy_s[cfg_act.src]) begin
            src_sel <= cfg_act.src;
        end
    end

    assign src_req = onehot_src(src_sel) | onehot_src(cfg_act.src);
endmodule

// File: rtl/clkgen_divider.sv
module clkgen_divider
    import clkgen_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  gen_cfg_t cfg,
    input  logic     swr,
    output logic     running,
    output logic     wrap,
    output logic     clk_out
);
    logic [CNT_W-1:0] cnt, nx_cnt, n_per, half;
    logic             nx_run;
    logic             out_pos, out_neg, pt_n, stretch_n;

    assign n_per = period_of(cfg);
    assign half  = n_per >> 1;
    assign wrap  = running && (cnt >= n_per - CNT_W'(1));

    always_comb begin
        nx_run = running;
        nx_cnt = cnt;
        if (swr) begin
            nx_run = 1'b0;
            nx_cnt = '0;
        end else if (!running) begin
            if (cfg.run) begin
                nx_run = 1'b1;
                nx_cnt = '0;
            end
        end else if (wrap) begin
            nx_cnt = '0;
            if (!cfg.run) nx_run = 1'b0;
        end else begin
            nx_cnt = cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cnt     <= '0;
            out_pos <= 1'b0;
        end else begin
            running <= nx_run;
            cnt     <= nx_cnt;
            if (nx_run)   out_pos <= (nx_cnt < half);
            else if (swr) out_pos <= 1'b0;
            else          out_pos <= cfg.oov;
        end
    end

    // Falling-edge copies: half-cycle stretch and pass-through gating.
    always_ff @(negedge clk) begin
        if (rst) begin
            out_neg   <= 1'b0;
            pt_n      <= 1'b0;
            stretch_n <= 1'b0;
        end else begin
            out_neg   <= out_pos;
            pt_n      <= running && (n_per == CNT_W'(1));
            stretch_n <= stretch_of(cfg);
        end
    end

    assign clk_out = pt_n ? clk : (out_pos | (stretch_n & out_neg));
endmodule

// File: rtl/clkgen_div.sv
module clkgen_div
    import clkgen_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             bus_clk,
    input  logic             bus_rst,
    input  logic             gen_clk,
    input  logic             gen_rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_op,
    input  logic [SRC_W-1:0] wr_src,
    input  logic [DIV_W-1:0] wr_div,
    input  logic             wr_pow2,
    input  logic             wr_oov,
    input  logic             wr_dcc,
    input  logic             wr_pin_oe,
    input  logic             wr_stby,
    input  logic             wr_run,
    output logic             busy,
    output logic             gen_on,
    input  logic [NSRC-1:0]  src_rdy,
    output logic [NSRC-1:0]  src_req,
    output logic [SRC_W-1:0] src_sel,
    output logic             clk_out,
    output logic             clk_pin,
    output logic             stby_keep
);
    gen_cfg_t        wr_cfg, sh_cfg, cfg_act;
    gen_op_e         sh_op;
    logic            req_tgl, req_s, ack_tgl, ack_s;
    logic            g_running, g_wrap, g_swr;
    logic [NSRC-1:0] rdy_s;

    assign wr_cfg = '{src: wr_src, div: wr_div, pow2: wr_pow2, oov: wr_oov,
                      dcc: wr_dcc, pin_oe: wr_pin_oe, stby: wr_stby, run: wr_run};

    clkgen_bus_port u_bus (
        .clk(bus_clk), .rst(bus_rst), .wr_en(wr_en), .wr_op(gen_op_e'(wr_op)),
        .wr_cfg(wr_cfg), .ack_s(ack_s), .req_tgl(req_tgl), .sh_cfg(sh_cfg),
        .sh_op(sh_op), .busy(busy)
    );

    clkgen_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_req_sync (
        .clk(gen_clk), .rst(gen_rst), .d(req_tgl), .q(req_s)
    );

    clkgen_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(bus_clk), .rst(bus_rst), .d(ack_tgl), .q(ack_s)
    );

    clkgen_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_on_sync (
        .clk(bus_clk), .rst(bus_rst), .d(g_running), .q(gen_on)
    );

    clkgen_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_rdy_sync (
        .clk(gen_clk), .rst(gen_rst), .d(src_rdy), .q(rdy_s)
    );

    clkgen_gen_ctrl u_ctrl (
        .clk(gen_clk), .rst(gen_rst), .req_s(req_s), .sh_cfg(sh_cfg),
        .sh_op(sh_op), .running(g_running), .rdy_s(rdy_s), .cfg_act(cfg_act),
        .swr(g_swr), .ack_tgl(ack_tgl), .src_req(src_req), .src_sel(src_sel)
    );

    clkgen_divider u_div (
        .clk(gen_clk), .rst(gen_rst), .cfg(cfg_act), .swr(g_swr),
        .running(g_running), .wrap(g_wrap), .clk_out(clk_out)
    );

    assign clk_pin   = cfg_act.pin_oe & clk_out;
    assign stby_keep = cfg_act.stby;
endmodule

// File: rtl/clkgen_div_chk.sv
module clkgen_div_chk
    import clkgen_pkg::*;
(
    input logic            bus_clk,
    input logic            bus_rst,
    input logic            gen_clk,
    input logic            gen_rst,
    input logic            wr_en,
    input logic            busy,
    input logic            gen_on,
    input gen_cfg_t        sh_cfg,
    input gen_op_e         sh_op,
    input logic            g_running,
    input logic            g_wrap,
    input logic            g_swr,
    input logic [NSRC-1:0] src_req
);
    assert_busy_rise_R6: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (wr_en && !busy) |=> busy);

    assert_drop_when_busy_R7: assert property (@(posedge bus_clk) disable iff (bus_rst)
        busy |=> $stable(sh_cfg));

    assert_stop_settled_R9: assert property (@(posedge bus_clk) disable iff (bus_rst)
        ($fell(busy) && (sh_op == OP_RUN)) |-> (gen_on == sh_cfg.run));

    assert_stop_on_boundary_R10: assert property (@(posedge gen_clk) disable iff (gen_rst)
        $fell(g_running) |-> ($past(g_wrap) || $past(g_swr)));

    assert_request_count_R11: assert property (@(posedge gen_clk) disable iff (gen_rst)
        ($countones(src_req) >= 1) && ($countones(src_req) <= 2));
endmodule

bind clkgen_div clkgen_div_chk u_chk (
    .bus_clk(bus_clk), .bus_rst(bus_rst), .gen_clk(gen_clk), .gen_rst(gen_rst),
    .wr_en(wr_en), .busy(busy), .gen_on(gen_on), .sh_cfg(sh_cfg), .sh_op(sh_op),
    .g_running(g_running), .g_wrap(g_wrap), .g_swr(g_swr), .src_req(src_req)
);

// File: tb/sim_clkgen_div.sv
`timescale 1ns/100ps
module sim_clkgen_div;
    logic       bus_clk = 1'b0, gen_clk = 1'b0;
    logic       bus_rst = 1'b1, gen_rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_op = 2'd0;
    logic [1:0] wr_src = 2'd0;
    logic [7:0] wr_div = 8'd0;
    logic       wr_pow2 = 1'b0, wr_oov = 1'b0, wr_dcc = 1'b0;
    logic       wr_pin_oe = 1'b0, wr_stby = 1'b0, wr_run = 1'b0;
    logic       busy, gen_on, clk_out, clk_pin, stby_keep;
    logic [3:0] src_rdy = 4'hF;
    logic [3:0] src_req;
    logic [1:0] src_sel;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;
    logic [1:0] b_src = 0;
    logic b_pe = 0, b_st = 0;

    always #5 bus_clk = ~bus_clk;
    always #4 gen_clk = ~gen_clk;

    clkgen_div u0 (
        .bus_clk(bus_clk), .bus_rst(bus_rst), .gen_clk(gen_clk), .gen_rst(gen_rst),
        .wr_en(wr_en), .wr_op(wr_op), .wr_src(wr_src), .wr_div(wr_div),
        .wr_pow2(wr_pow2), .wr_oov(wr_oov), .wr_dcc(wr_dcc), .wr_pin_oe(wr_pin_oe),
        .wr_stby(wr_stby), .wr_run(wr_run), .busy(busy), .gen_on(gen_on),
        .src_rdy(src_rdy), .src_req(src_req), .src_sel(src_sel),
        .clk_out(clk_out), .clk_pin(clk_pin), .stby_keep(stby_keep)
    );

    // Pulse-width monitor on the output
    realtime last_t = 0, min_w = 1.0e9;
    bit mon = 0, mon_first = 1;
    always @(clk_out) begin
        if (mon) begin
            if (!mon_first && ($realtime - last_t) < min_w) min_w = $realtime - last_t;
            mon_first = 0;
            last_t = $realtime;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [1:0] op, input logic [7:0] d, input logic p2,
                       input logic ov, input logic dc, input logic rn);
        @(negedge bus_clk);
        wr_en = 1; wr_op = op; wr_div = d; wr_pow2 = p2; wr_oov = ov; wr_dcc = dc;
        wr_run = rn; wr_src = b_src; wr_pin_oe = b_pe; wr_stby = b_st;
        @(negedge bus_clk);
        wr_en = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            if (!busy) break;
            @(negedge bus_clk);
        end
        check(!busy, "R6", "busy clears", longint'(busy), 0);
    endtask

    task automatic wr(input logic [1:0] op, input logic [7:0] d, input logic p2,
                      input logic ov, input logic dc, input logic rn);
        wait_idle();
        put(op, d, p2, ov, dc, rn);
        check(busy, "R6", "busy after write", longint'(busy), 1);
        wait_idle();
    endtask

    task automatic find_edge(input logic lvl, output realtime t, output bit ok);
        logic prev;
        ok = 0; t = 0;
        #0.5;
        prev = clk_out;
        for (int i = 0; i < 20000; i++) begin
            #1;
            if (clk_out == lvl && prev != lvl) begin
                t = $realtime; ok = 1; break;
            end
            prev = clk_out;
        end
        #0.5;
    endtask

    task automatic measure(input int exp_p, input int exp_h, input string req);
        realtime t0, t1, t2;
        bit a, b, c, d;
        find_edge(1'b1, t0, a);
        find_edge(1'b1, t0, b);
        find_edge(1'b0, t1, c);
        find_edge(1'b1, t2, d);
        check(a && b && c && d, req, "edges seen", longint'(a && b && c && d), 1);
        check(longint'(t2 - t0) == exp_p, req, "period ns", longint'(t2 - t0), exp_p);
        check(longint'(t1 - t0) == exp_h, req, "high ns", longint'(t1 - t0), exp_h);
    endtask

    function automatic int ref_n(input int d, input bit p2);
        if (p2) return 1 << (d + 1);
        return (d <= 1) ? 1 : d;
    endfunction

    function automatic int ref_high(input int d, input bit p2, input bit dc);
        int n;
        n = ref_n(d, p2);
        if (n == 1) return 4;
        return (n / 2) * 8 + ((dc && !p2 && (n % 2 == 1) && n >= 3) ? 4 : 0);
    endfunction

    initial begin
        #1500000;
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (6) @(negedge bus_clk);
        bus_rst = 0; gen_rst = 0;
        repeat (4) @(negedge bus_clk);

        // Reset state
        check(!busy, "R6", "busy after reset", longint'(busy), 0);
        check(!gen_on, "R12", "gen_on after reset", longint'(gen_on), 0);
        check(!clk_out, "R5", "idle level after reset", longint'(clk_out), 0);
        check(src_req == 4'b0001, "R12", "src_req after reset", longint'(src_req), 1);

        // Integer sweep: pass-through and plain division
        wr(2'd0, 8'd0, 0, 0, 0, 0);
        wr(2'd1, 8'd0, 0, 0, 0, 1);
        check(gen_on, "R9", "gen_on after start", longint'(gen_on), 1);
        for (int d = 0; d <= 8; d++) begin
            wr(2'd0, 8'(d), 0, 0, 0, 0);
            measure(ref_n(d, 0) * 8, ref_high(d, 0, 0), (d <= 1) ? "R3" : "R2");
        end

        // Duty stretch on odd and even ratios
        for (int d = 3; d <= 8; d++) begin
            wr(2'd0, 8'(d), 0, 0, 1, 0);
            measure(ref_n(d, 0) * 8, ref_high(d, 0, 1), "R4");
        end

        // Power-of-two sweep
        for (int d = 0; d <= 8; d++) begin
            wr(2'd0, 8'(d), 1, 0, 0, 0);
            measure(ref_n(d, 1) * 8, ref_high(d, 1, 0), "R1");
        end

        // Stop during a long period: busy must outlast the period (R9)
        wait_idle();
        put(2'd1, 8'd0, 0, 0, 0, 0);
        repeat (50) @(negedge bus_clk);
        check(busy, "R9", "busy held during stop", longint'(busy), 1);
        check(gen_on, "R9", "gen_on held during stop", longint'(gen_on), 1);
        wait_idle();
        check(!gen_on, "R9", "gen_on after stop", longint'(gen_on), 0);
        check(!clk_out, "R9", "idle level at stop", longint'(clk_out), 0);

        // Configure keeps run bit, run op touches only run (R8)
        wr(2'd1, 8'd0, 0, 0, 0, 1);
        wr(2'd0, 8'd4, 0, 0, 0, 0);
        check(gen_on, "R8", "run kept by configure", longint'(gen_on), 1);
        measure(32, 16, "R8");
        wr(2'd1, 8'd6, 0, 1, 0, 0);
        check(!gen_on, "R8", "run op stops", longint'(gen_on), 0);
        check(!clk_out, "R8", "idle level unchanged by run op", longint'(clk_out), 0);
        wr(2'd1, 8'd6, 0, 1, 0, 1);
        measure(32, 16, "R8");
        wr(2'd3, 8'd7, 1, 1, 1, 0);
        check(gen_on, "R8", "no-op keeps running", longint'(gen_on), 1);
        measure(32, 16, "R8");

        // Glitch-free start/stop with both idle levels (R10, R5)
        mon = 1; mon_first = 1; min_w = 1.0e9;
        wr(2'd1, 8'd4, 0, 0, 0, 0);
        repeat (20) @(negedge bus_clk);
        wr(2'd1, 8'd4, 0, 0, 0, 1);
        repeat (20) @(negedge bus_clk);
        wr(2'd0, 8'd4, 0, 1, 0, 0);
        wr(2'd1, 8'd4, 0, 1, 0, 0);
        check(clk_out, "R5", "high idle level", longint'(clk_out), 1);
        begin
            bit held;
            held = 1;
            for (int i = 0; i < 100; i++) begin
                #1;
                if (!clk_out) held = 0;
            end
            check(held, "R5", "idle level held", longint'(held), 1);
        end
        wr(2'd1, 8'd4, 0, 1, 0, 1);
        repeat (20) @(negedge bus_clk);
        mon = 0;
        check(min_w >= 16.0, "R10", "min pulse ns", longint'(min_w), 16);

        // Write during busy is dropped (R7)
        wait_idle();
        put(2'd0, 8'd3, 0, 0, 0, 0);
        put(2'd0, 8'd7, 0, 0, 0, 0);
        wait_idle();
        measure(24, 8, "R7");

        // Pin output and standby field (R13)
        b_pe = 1; b_st = 1;
        wr(2'd0, 8'd2, 0, 0, 0, 0);
        begin
            bit same, low;
            same = 1;
            for (int i = 0; i < 40; i++) begin
                #1;
                if (clk_pin !== clk_out) same = 0;
            end
            check(same, "R13", "pin follows output", longint'(same), 1);
            check(stby_keep, "R13", "standby field", longint'(stby_keep), 1);
            b_pe = 0;
            wr(2'd0, 8'd2, 0, 0, 0, 0);
            low = 1;
            for (int i = 0; i < 40; i++) begin
                #1;
                if (clk_pin) low = 0;
            end
            check(low, "R13", "pin low when disabled", longint'(low), 1);
        end

        // Source change keeps old request until ready (R11)
        src_rdy = 4'b1011;
        b_src = 2'd2;
        wr(2'd0, 8'd2, 0, 0, 0, 0);
        repeat (10) @(negedge bus_clk);
        check(src_req == 4'b0101, "R11", "both requests", longint'(src_req), 5);
        check(src_sel == 2'd0, "R11", "old source held", longint'(src_sel), 0);
        src_rdy = 4'b1111;
        repeat (10) @(negedge bus_clk);
        check(src_req == 4'b0100, "R11", "new request only", longint'(src_req), 4);
        check(src_sel == 2'd2, "R11", "new source selected", longint'(src_sel), 2);

        // Software reset op restores defaults (R12)
        b_src = 2'd0; b_st = 0;
        wr(2'd0, 8'd5, 0, 1, 0, 0);
        wr(2'd2, 8'd9, 1, 1, 1, 1);
        repeat (10) @(negedge bus_clk);
        check(!gen_on, "R12", "stopped by reset op", longint'(gen_on), 0);
        check(!clk_out, "R12", "default idle level", longint'(clk_out), 0);
        check(src_sel == 2'd0 && src_req == 4'b0001, "R12", "default source",
              longint'(src_req), 1);
        wr(2'd1, 8'd9, 1, 1, 1, 1);
        measure(8, 4, "R12");

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule